// File: doc/BRIEF.md
# Recent Command History Buffer

This block records every command word the terminal receives and keeps the 32 newest in a circular store. Each capture strobe writes the presented word into the next slot. Once all 32 slots hold data, each new capture replaces the oldest word. Nothing on the bus side can write the store. Its contents are cleared only by the core reset. Interface-level resets do not reach this block.

A readout starts with a request that carries a word count. The block takes a snapshot of the newest slot and presents that word on `rd_word` in the cycle after the request. Each read strobe then steps one slot back in time, wrapping modulo the depth, until the requested number of words has been offered. Reading never removes entries, so the same history can be read as often as needed. Slots that have not been written since reset read back as zero.

Top module: `cmd_history`

## Requirements
- R1: After `rst_n` is held low for a clock edge, `rd_active` is 0, `rd_word` is 0000h and every one of the 32 slots reads back as 0000h.
- R2: Each clock edge with `cap_valid` high stores `cap_word` in the next slot, modulo 32. After more than 32 captures only the 32 newest words remain.
- R3: A clock edge with `rd_start` high and a nonzero `rd_len` makes `rd_active` 1 in the following cycle, with `rd_word` showing the most recently captured word.
- R4: Each clock edge with `rd_strobe` high while `rd_active` is 1 moves `rd_word` to the next older slot, wrapping from slot 0 to slot 31.
- R5: After as many strobes as the effective length, `rd_active` returns to 0. While `rd_active` is 0, `rd_word` is 0000h.
- R6: Reading does not alter the store: a second readout returns the same words as the first.
- R7: A slot never written since reset is read out as 0000h.
- R8: A capture during a readout is stored, but it does not move the running readout. The readout continues through the older words. The captured word becomes the newest word for the next readout.
- R9: When `rd_start` and `cap_valid` are high on the same edge, the snapshot is taken before that capture. The readout's first word is the previous newest word.
- R10: `rd_strobe` while `rd_active` is 0 has no effect: `rd_word` stays 0000h and the next readout still starts at the newest word.
- R11: `rd_len` of 0 starts no readout. A value above 32 is treated as 32.
- R12: `rd_start` during an active readout restarts it from the newest word with the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Core reset, synchronous, active low; clears the store and the readout |
| cap_valid | input | 1 | Capture strobe for a received command word |
| cap_word | input | 16 | Command word to store |
| rd_start | input | 1 | Starts (or restarts) a readout |
| rd_len | input | 6 | Word count of the readout, 1 to 32 (0 ignored, above 32 clamped) |
| rd_strobe | input | 1 | Consumes the presented word and steps to the next older one |
| rd_word | output | 16 | Word currently offered by the readout, 0000h when idle |
| rd_active | output | 1 | High while the readout still has words to offer |

## Verification
On every cycle, the assertions check the pointer arithmetic. The write slot advances exactly once per capture. A readout request loads the slot just behind the write slot. Each strobe during a readout steps the read slot back by one. An idle strobe leaves the read slot untouched, and the remaining count never exceeds the depth. Only the bench's scenarios can show what the store returns. These include the newest-first word order across a wrap of the 32 slots, the zero contents of unwritten slots, repeated non-destructive readouts, and the ordering of a capture against a readout start or a readout in flight.

// File: rtl/chb_pkg.sv
// Package for the command history buffer: default geometry shared by all modules.
// Assumes the depth is a power of two so that pointer arithmetic wraps naturally.
package chb_pkg;
    localparam int CHB_DEPTH = 32;
    localparam int CHB_WIDTH = 16;
endpackage

// File: rtl/chb_store.sv
// Slot store: DEPTH words of WIDTH bits with one write port and one
// asynchronous read port. All slots clear on the core reset so that
// unwritten slots read as zero (R1, R7).
module chb_store #(
    parameter int DEPTH = chb_pkg::CHB_DEPTH,
    parameter int WIDTH = chb_pkg::CHB_WIDTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slots [DEPTH];

    // Write or clear each slot; every slot has its own enable.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[i] <= '0;
            else if (we && waddr == AW'(i))
                slots[i] <= wdata;
        end
    end

    // Read mux for the readout side.
    assign rdata = slots[raddr];
endmodule

// File: rtl/chb_wptr.sv
// Write slot counter: advances modulo DEPTH on each capture (R2).
// Assumes DEPTH is a power of two.
module chb_wptr #(
    parameter int DEPTH = chb_pkg::CHB_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] wptr
);
    // Next-slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (adv)
            wptr <= wptr + AW'(1);
    end

    // R2: one capture moves the write slot by exactly one.
    p_wptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> wptr == $past(wptr) + AW'(1));
    // R2: no capture, no movement.
    p_wptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(wptr));
endmodule

// File: rtl/chb_reader.sv
// Readout sequencer: snapshots the newest slot on a start request and
// walks backwards one slot per strobe until the requested count is used.
// Assumes DEPTH is a power of two; a length of 0 is ignored and a length
// above DEPTH is clamped to DEPTH.
module chb_reader #(
    parameter int DEPTH = chb_pkg::CHB_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic          strobe,
    input  logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          active
);
    logic [LW-1:0] remaining;
    logic [LW-1:0] eff_len;

    // Clamp the requested length to the depth (R11).
    assign eff_len = (len > LW'(DEPTH)) ? LW'(DEPTH) : len;
    assign active  = (remaining != '0);

    // Load the snapshot on start, step back on each strobe while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr      <= '0;
            remaining <= '0;
        end else if (start && eff_len != '0) begin
            rptr      <= wptr - AW'(1);
            remaining <= eff_len;
        end else if (strobe && active) begin
            rptr      <= rptr - AW'(1);
            remaining <= remaining - LW'(1);
        end
    end

    // R3: a valid start points at the newest slot and activates the readout.
    p_load_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> (active && rptr == $past(wptr) - AW'(1)));
    // R4: a strobe during a readout steps one slot older.
    p_step_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && strobe && active) |=> rptr == $past(rptr) - AW'(1));
    // R10: an idle strobe changes nothing.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(start && len != '0) && !active) |=> ($stable(rptr) && !active));
    // R11: the remaining count never exceeds the depth.
    p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= LW'(DEPTH));
endmodule

// File: rtl/cmd_history.sv
// Top of the recent command history buffer: captures each received command
// word into a circular store and reads the newest words back, newest first.
// Assumes only the core reset clears the store; there is no bus-side write.
module cmd_history #(
    parameter int DEPTH = chb_pkg::CHB_DEPTH,
    parameter int WIDTH = chb_pkg::CHB_WIDTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic [WIDTH-1:0] cap_word,
    input  logic             rd_start,
    input  logic [LW-1:0]    rd_len,
    input  logic             rd_strobe,
    output logic [WIDTH-1:0] rd_word,
    output logic             rd_active
);
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [WIDTH-1:0] slot_data;

    chb_wptr #(.DEPTH(DEPTH)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cap_valid),
        .wptr  (wptr)
    );

    chb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cap_valid),
        .waddr (wptr),
        .wdata (cap_word),
        .raddr (rptr),
        .rdata (slot_data)
    );

    chb_reader #(.DEPTH(DEPTH)) u_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rd_start),
        .len    (rd_len),
        .strobe (rd_strobe),
        .wptr   (wptr),
        .rptr   (rptr),
        .active (rd_active)
    );

    // Present the walked slot only while a readout is running (R5).
    assign rd_word = rd_active ? slot_data : '0;

    // R3: a start with no concurrent capture presents the word captured just before it.
    p_newest_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !rd_start) ##1 (rd_start && rd_len != '0 && !cap_valid)
        |=> rd_word == $past(cap_word, 2));
endmodule

// File: tb/cmd_history_test.sv
// Self-checking bench for cmd_history: a vector table then directed cases.
module cmd_history_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;
    // Vector: {op[1:0], value[15:0], req[3:0]}.
    // op 0 capture value, 1 start with length value,
    // 2 check rd_word == value then strobe, 3 check idle.
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 16'h1111, 4'd2},  // R2
        {2'd0, 16'h2222, 4'd2},
        {2'd0, 16'h3333, 4'd2},
        {2'd1, 16'd3,    4'd3},
        {2'd2, 16'h3333, 4'd3},  // R3 newest first
        {2'd2, 16'h2222, 4'd4},  // R4
        {2'd2, 16'h1111, 4'd4},
        {2'd3, 16'h0000, 4'd5},  // R5
        {2'd1, 16'd5,    4'd6},
        {2'd2, 16'h3333, 4'd6},  // R6 same again
        {2'd2, 16'h2222, 4'd6},
        {2'd2, 16'h1111, 4'd6},
        {2'd2, 16'h0000, 4'd7},  // R7 unwritten slot 31 after wrap
        {2'd2, 16'h0000, 4'd7},
        {2'd3, 16'h0000, 4'd5},
        {2'd1, 16'd1,    4'd3},
        {2'd2, 16'h3333, 4'd3},
        {2'd3, 16'h0000, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [15:0] cap_word = '0;
    logic        rd_start = 1'b0;
    logic [5:0]  rd_len = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_word;
    logic        rd_active;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    cmd_history uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_word  (cap_word),
        .rd_start  (rd_start),
        .rd_len    (rd_len),
        .rd_strobe (rd_strobe),
        .rd_word   (rd_word),
        .rd_active (rd_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Apply one cycle of stimulus; results are sampled 1 time unit after the edge.
    task automatic tick(input logic cv, input logic [15:0] cd, input logic st,
                        input logic [5:0] ln, input logic sb);
        cap_valid = cv; cap_word = cd; rd_start = st; rd_len = ln; rd_strobe = sb;
        @(posedge clk);
        #1;
        cap_valid = 1'b0; rd_start = 1'b0; rd_strobe = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic [15:0] exp);
        chk(tag, rd_word, exp);
        chk(tag, {15'd0, rd_active}, 16'd1);
        tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b1);
    endtask

    task automatic idle(input string tag);
        chk(tag, {15'd0, rd_active}, 16'd0);
        chk(tag, rd_word, 16'h0000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b0);
        tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        #1;
        do_reset();
        idle("R1 reset state");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [15:0] val;
            string       tag;
            op  = VEC[i][21:20];
            val = VEC[i][19:4];
            tag = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
            case (op)
                2'd0: tick(1'b1, val, 1'b0, 6'd0, 1'b0);
                2'd1: tick(1'b0, 16'h0, 1'b1, val[5:0], 1'b0);
                2'd2: step(tag, val);
                default: idle(tag);
            endcase
        end

        // R2 / R4: wrap the store with 40 captures, read all 32 newest first.
        do_reset();
        for (int k = 0; k < 40; k++) tick(1'b1, 16'hA000 + 16'(k), 1'b0, 6'd0, 1'b0);
        tick(1'b0, 16'h0, 1'b1, 6'd32, 1'b0);
        for (int k = 39; k >= 8; k--) step("R2 wrap keeps newest 32", 16'hA000 + 16'(k));
        idle("R5 end of full readout");

        // R8: capture in flight leaves the running readout on its path.
        tick(1'b0, 16'h0, 1'b1, 6'd4, 1'b0);
        step("R8 first", 16'hA027);
        tick(1'b1, 16'hBEEF, 1'b0, 6'd0, 1'b0);
        chk("R8 pointer unmoved by capture", rd_word, 16'hA026);
        step("R8 continue", 16'hA026);
        step("R8 continue", 16'hA025);
        step("R8 continue", 16'hA024);
        idle("R8 end");
        tick(1'b0, 16'h0, 1'b1, 6'd1, 1'b0);
        step("R8 new word is newest", 16'hBEEF);

        // R9: start and capture on the same edge.
        tick(1'b1, 16'hCAFE, 1'b1, 6'd2, 1'b0);
        step("R9 snapshot before capture", 16'hBEEF);
        step("R9 older", 16'hA027);
        idle("R9 end");
        tick(1'b0, 16'h0, 1'b1, 6'd1, 1'b0);
        step("R9 capture stored", 16'hCAFE);

        // R10: idle strobes have no effect.
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b1);
            idle("R10 idle strobe");
        end
        tick(1'b0, 16'h0, 1'b1, 6'd1, 1'b0);
        step("R10 newest unchanged", 16'hCAFE);

        // R11: zero length ignored, oversize length clamped.
        tick(1'b0, 16'h0, 1'b1, 6'd0, 1'b0);
        idle("R11 zero length");
        tick(1'b0, 16'h0, 1'b1, 6'd50, 1'b0);
        chk("R11 clamped first word", rd_word, 16'hCAFE);
        for (int k = 0; k < 31; k++) tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b1);
        chk("R11 still active at 32nd word", {15'd0, rd_active}, 16'd1);
        tick(1'b0, 16'h0, 1'b0, 6'd0, 1'b1);
        idle("R11 ends after 32");

        // R12: restart during an active readout.
        tick(1'b0, 16'h0, 1'b1, 6'd3, 1'b0);
        step("R12 before restart", 16'hCAFE);
        tick(1'b0, 16'h0, 1'b1, 6'd2, 1'b0);
        step("R12 restarted at newest", 16'hCAFE);
        step("R12 second", 16'hBEEF);
        idle("R12 new length honoured");

        // R1 / R7: core reset clears every slot.
        do_reset();
        idle("R1 after second reset");
        tick(1'b0, 16'h0, 1'b1, 6'd32, 1'b0);
        for (int k = 0; k < 32; k++) step("R1 slot cleared", 16'h0000);
        idle("R1 end");

        summary();
    end
endmodule